// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Cache

This block sits between a processor-side request port and a word-addressed backing memory. Each word address is split into a tag, a set index and a word offset. On every request, the block compares the tag against all four ways of the selected set. A request that hits completes in the same cycle it is presented. A write hit changes only the cached copy and marks the line as modified.

On a miss, the block chooses a victim way inside the set. An empty way is taken first. Otherwise a three-bit tree approximation of least-recently-used picks the victim. A modified victim is first written back word by word. The whole four-word block holding the requested word is then read from memory. After that the access is retried internally, and this time it hits. The processor keeps its request stable until `ready_o` is asserted.

Top module: `sa_cache`

## Requirements
- R1: The word address splits as tag = addr[7:4], set = addr[3:2] and word offset = addr[1:0] (defaults). Blocks with the same tag but different set index occupy separate sets and do not evict each other.
- R2: A read whose set holds a valid way with a matching tag asserts `ready_o` in the cycle it is presented, with `rdata_o` equal to the addressed word, and causes no memory traffic.
- R3: On a miss, the block issues four memory reads at the block base address with offsets 0, 1, 2 and 3, in that order. It then returns the requested word with `ready_o`.
- R4: After a refill, every word of the block hits without memory traffic.
- R5: A write hit updates only the cache and causes no memory write. A later read of that word returns the written value.
- R6: When the victim is valid and modified, its four words are written to memory at the victim's old block address, offsets 0 to 3, before any refill read begins.
- R7: A clean or empty victim is replaced with no memory write.
- R8: While any way of a set is invalid, a miss fills the lowest-numbered invalid way. As a result, four different tags in one set all stay resident.
- R9: Each set keeps a root bit that selects the less recently used pair of ways, and one bit per pair that selects the less recently used way within it. Every hit or fill points both bits on its path away from the accessed way, and a miss in a full set evicts the way those bits select.
- R10: After reset, all lines are invalid, `ready_o` and `mem_req_o` are low, and the first access misses.
- R11: `ready_o` is asserted only while a request is present, once per completed access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request, held until ready |
| we_i | input | 1 | Request is a write |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Access completes this cycle |
| rdata_o | output | DATA_W | Read data, valid with ready |
| mem_req_o | output | 1 | Memory transfer request, held until ack |
| mem_we_o | output | 1 | Memory transfer is a write |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory transfer done |

## Verification
The hardest case to reach is eviction of a modified line chosen by the tree bits rather than by the empty-way rule. Reaching it requires a full set, a hit that steers the root bit to the other pair, and a fill that flips it back. The stimulus fills one set with four tags, re-reads one of them so that the pseudo-LRU choice differs from true LRU, and forces a clean eviction. Further hits then steer the bits onto the dirty line. Memory transactions are logged in order, so the write-back, its addresses and its position ahead of the refill reads can all be checked.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL} cache_state_e;

  // way selected by tree bits: [0] pair pick, [1] pair0 way, [2] pair1 way
  function automatic logic [WAY_W-1:0] tree_pick(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction
endpackage

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup
  import sa_cache_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) way_o = WAY_W'(w);
  end
  assign hit_o = |hit_vec;

  // R2
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/sa_cache_plru.sv
module sa_cache_plru
  import sa_cache_pkg::*;
#(
  parameter int SET_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             upd_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [WAY_W-1:0] victim_o
);
  localparam int SETS = 1 << SET_W;

  logic [2:0] bits_q [SETS];

  always_comb begin
    victim_o = tree_pick(bits_q[set_i]);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_i[w]) victim_o = WAY_W'(w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
    end else if (upd_i) begin
      bits_q[set_i][0] <= ~upd_way_i[1];
      if (upd_way_i[1]) bits_q[set_i][2] <= ~upd_way_i[0];
      else              bits_q[set_i][1] <= ~upd_way_i[0];
    end
  end

  // R8
  empty_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i != '1) |-> !valid_i[victim_o]);
  // R9
  point_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (tree_pick(bits_q[$past(set_i)]) != $past(upd_way_i)));
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SET_W  = 2,
  parameter int OFF_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam int SETS  = 1 << SET_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - SET_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  cache_state_e state_q;
  logic [OFF_W-1:0] cnt_q;
  logic [WAY_W-1:0] vict_q, victim, hit_way;
  logic [WAYS-1:0] valid_q [SETS];
  logic [WAYS-1:0] dirty_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS][WORDS];
  logic [WAYS-1:0][TAG_W-1:0] set_tags;

  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] set;
  logic [OFF_W-1:0] off;
  logic hit, miss_go, wr_hit, fill_ack, fill_last, plru_upd;

  assign {req_tag, set, off} = addr_i;

  always_comb
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[set][w];

  sa_cache_lookup #(.TAG_W(TAG_W)) u_lookup (
    .clk_i, .rst_ni, .valid_i(valid_q[set]), .tags_i(set_tags),
    .tag_i(req_tag), .hit_o(hit), .way_o(hit_way)
  );

  sa_cache_plru #(.SET_W(SET_W)) u_plru (
    .clk_i, .rst_ni, .set_i(set), .valid_i(valid_q[set]), .upd_i(plru_upd),
    .upd_way_i(ready_o ? hit_way : vict_q), .victim_o(victim)
  );

  assign ready_o   = (state_q == ST_IDLE) && req_i && hit;
  assign rdata_o   = data_q[set][hit_way][off];
  assign miss_go   = (state_q == ST_IDLE) && req_i && !hit;
  assign wr_hit    = ready_o && we_i;
  assign fill_ack  = (state_q == ST_FILL) && mem_ack_i;
  assign fill_last = fill_ack && (cnt_q == LAST);
  assign plru_upd  = ready_o || fill_last;

  assign mem_req_o   = state_q != ST_IDLE;
  assign mem_we_o    = state_q == ST_WB;
  assign mem_addr_o  = {(state_q == ST_WB) ? tag_q[set][vict_q] : req_tag, set, cnt_q};
  assign mem_wdata_o = data_q[set][vict_q][cnt_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vict_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_go) begin
          vict_q  <= victim;
          cnt_q   <= '0;
          state_q <= (valid_q[set][victim] && dirty_q[set][victim]) ? ST_WB : ST_FILL;
        end
        ST_WB: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            valid_q[set][vict_q] <= 1'b1;
            dirty_q[set][vict_q] <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (wr_hit) dirty_q[set][hit_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_ack)    data_q[set][vict_q][cnt_q] <= mem_rdata_i;
    else if (wr_hit) data_q[set][hit_way][off]  <= wdata_i;
    if (fill_last)   tag_q[set][vict_q] <= req_tag;
  end

  // R5
  write_local_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> !mem_req_o);
  // R3
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ack && cnt_q != LAST) |=>
      (mem_addr_o[OFF_W-1:0] == $past(mem_addr_o[OFF_W-1:0]) + 1'b1));
  // R6
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q) == ST_WB) |-> $past(mem_ack_i && mem_we_o));
  // R11
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);
endmodule

// File: tb/sa_cache_tb_top.sv
module sa_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ready, mem_req, mem_we, mem_ack;
  logic [15:0] rdata, mem_wdata, mem_rdata;
  logic [7:0] mem_addr;

  int checks = 0, failures = 0;
  logic [15:0] mem [256];
  logic [15:0] gold [256];
  logic log_we [$];
  logic [7:0] log_addr [$];
  logic exp_rd [$];
  logic [15:0] exp_val [$];

  always #5 clk = ~clk;

  sa_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [15:0] init_val(input int a);
    return 16'(a * 257 + 3);
  endfunction

  // backing memory: serves one word per request, acks a cycle later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
      log_we.push_back(mem_we);
      log_addr.push_back(mem_addr);
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: compares each completed read against the queued expectation
  always @(negedge clk) begin
    if (ready && exp_rd.size() > 0) begin
      logic is_rd;
      logic [15:0] v;
      is_rd = exp_rd.pop_front();
      v = exp_val.pop_front();
      if (is_rd) chk("R2/R3 read data", {16'h0, rdata}, {16'h0, v});
    end
  end

  task automatic access(input logic w, input logic [7:0] a, input logic [15:0] d,
                        output int waits);
    log_we.delete();
    log_addr.delete();
    exp_rd.push_back(!w);
    exp_val.push_back(gold[a]);
    if (w) gold[a] = d;
    @(posedge clk); #1;
    req = 1'b1; we = w; addr = a; wdata = d;
    waits = 0;
    @(negedge clk);
    while (!ready) begin
      waits++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  // memory log must be nwr writes from wbase then nrd reads from rbase
  task automatic expect_log(input string r, input int nwr, input logic [7:0] wbase,
                            input int nrd, input logic [7:0] rbase);
    chk({r, " transfer count"}, log_we.size(), nwr + nrd);
    if (log_we.size() == nwr + nrd) begin
      for (int i = 0; i < nwr; i++) begin
        chk({r, " wb kind"}, {31'h0, log_we[i]}, 1);
        chk({r, " wb addr"}, {24'h0, log_addr[i]}, {24'h0, wbase + 8'(i)});
      end
      for (int i = 0; i < nrd; i++) begin
        chk({r, " fill kind"}, {31'h0, log_we[nwr+i]}, 0);
        chk({r, " fill addr"}, {24'h0, log_addr[nwr+i]}, {24'h0, rbase + 8'(i)});
      end
    end
  endtask

  task automatic hit_read(input string r, input logic [7:0] a);
    int wt;
    access(1'b0, a, '0, wt);
    chk({r, " hit wait"}, wt, 0);
    chk({r, " hit traffic"}, log_we.size(), 0);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int wt;
    for (int i = 0; i < 256; i++) gold[i] = init_val(i);
    repeat (3) @(posedge clk);
    #1;
    // R10: idle outputs in and after reset
    chk("R10 ready in reset", {31'h0, ready}, 0);
    chk("R10 mem_req in reset", {31'h0, mem_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 mem_req idle", {31'h0, mem_req}, 0);
    // R11: no ready without request
    chk("R11 ready without req", {31'h0, ready}, 0);

    // R3 R10 R7: first access misses, clean fill of 0x10..0x13
    access(1'b0, 8'h10, '0, wt);
    chk("R10 first access misses", {31'h0, wt > 0}, 1);
    expect_log("R3", 0, 8'h00, 4, 8'h10);

    // R4 R2: neighbour words hit
    hit_read("R4", 8'h12);
    hit_read("R2", 8'h11);

    // R5: write hit stays local
    access(1'b1, 8'h13, 16'hBEEF, wt);
    chk("R5 write wait", wt, 0);
    chk("R5 write traffic", log_we.size(), 0);
    chk("R5 memory untouched", {16'h0, mem[8'h13]}, {16'h0, init_val(8'h13)});
    hit_read("R5 readback", 8'h13);

    // R8: fill remaining ways of set 0; all four tags stay resident
    access(1'b0, 8'h20, '0, wt); expect_log("R8 way1", 0, 8'h00, 4, 8'h20);
    access(1'b0, 8'h30, '0, wt); expect_log("R8 way2", 0, 8'h00, 4, 8'h30);
    access(1'b0, 8'h40, '0, wt); expect_log("R8 way3", 0, 8'h00, 4, 8'h40);
    hit_read("R8", 8'h10);
    hit_read("R8", 8'h20);
    hit_read("R8", 8'h30);
    hit_read("R8", 8'h40);

    // R9: touch tag 1 -> tree points at way2 (tag 3), unlike true LRU (tag 2)
    hit_read("R9", 8'h10);
    access(1'b0, 8'h51, '0, wt);
    expect_log("R9 R7 clean evict", 0, 8'h00, 4, 8'h50);
    hit_read("R9 kept", 8'h10);
    hit_read("R9 kept", 8'h21);
    hit_read("R9 kept", 8'h42);

    // R6: tree now selects way0 (dirty tag 1): write back then refill
    access(1'b0, 8'h30, '0, wt);
    expect_log("R6 dirty evict", 4, 8'h10, 4, 8'h30);
    chk("R6 written word", {16'h0, mem[8'h13]}, 32'h0000BEEF);
    chk("R6 clean word", {16'h0, mem[8'h12]}, {16'h0, init_val(8'h12)});
    access(1'b0, 8'h13, '0, wt);
    expect_log("R6 refetch", 0, 8'h00, 4, 8'h10);

    // R1: same tag, other set lives apart
    access(1'b0, 8'h1D, '0, wt);
    expect_log("R1 set3 fill", 0, 8'h00, 4, 8'h1C);
    hit_read("R1 set0 intact", 8'h10);
    hit_read("R1 set3", 8'h1F);

    // R11: ready stays low once the request is dropped
    repeat (3) @(negedge clk);
    chk("R11 ready idle", {31'h0, ready}, 0);
    chk("R11 scoreboard drained", exp_rd.size(), 0);
    report();
  end
endmodule